// File: doc/BRIEF.md
# PPS-Latched Seconds/Ticks Timekeeper

This block keeps a 64-bit time value made of a seconds count (upper half) and a sub-second ticks count (lower half). The ticks advance once per clock and wrap to zero at a programmable ticks-per-second rate. When they wrap, the seconds count steps by one in the same cycle.

Software stages a new time through indexed settings writes. It writes a pending seconds value and a pending ticks value first. A write to the latch-control index then says when the pending pair takes effect. A value of one loads it at once. A value of zero arms a single load on the next edge of a pulse-per-second signal. Two PPS inputs are available, and a flags register selects the source and the active edge. The selected pulse passes through a two-flop sampler, and an edge is found by comparing the two most recent sampled values.

Top module: `pps_timekeeper`

## Requirements
- R1: While `rst` is high, `time_now` is zero, the flags are zero (falling edge, external input) and no load is armed. The counting starts on the first clock after reset is released.
- R2: Each clock with no load, the ticks field (`time_now[31:0]`) increments by one. When ticks+1 is greater than or equal to `tick_rate`, the ticks field returns to 0 and the seconds field (`time_now[63:32]`) increments in the same cycle. A rate of 0 or 1 therefore steps seconds every clock.
- R3: Writes to index 28 (pending seconds) and index 29 (pending ticks) do not change `time_now`. They only stage a value.
- R4: A write to index 31 with data bit 0 = 1 loads the pending pair. The first `time_now` after the clock edge that takes the write equals {pending seconds, pending ticks}, and counting continues from there.
- R5: A write to index 31 with data bit 0 = 0 arms a load. The armed load happens at the first active edge of the selected PPS that occurs after the arming cycle. It happens only once: later edges do not reload.
- R6: Flag bit 0 (index 30) selects the active PPS edge: 0 means falling, 1 means rising. The opposite edge does not trigger an armed load.
- R7: Flag bit 1 (index 30) selects the PPS source: 0 means `pps_ext`, 1 means `pps_b2b`. Edges on the unselected input have no effect.
- R8: After the selected input changes between clock edges, an armed load appears in `time_now` after the third rising clock edge and not earlier.
- R9: A load takes priority over counting. If a load and a ticks rollover fall in the same cycle, the result is the loaded value.
- R10: An immediate load while a PPS load is armed disarms it, so later edges do not load.
- R11: A PPS edge that falls in the same cycle as the arming write does not load. The unit is armed afterwards and loads on the next active edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Settings write strobe |
| cfg_idx | input | 5 | Settings register index |
| cfg_data | input | 32 | Settings write data |
| tick_rate | input | 32 | Ticks per second (wrap value) |
| pps_ext | input | 1 | PPS from the external connector |
| pps_b2b | input | 1 | PPS from the board-to-board link |
| time_now | output | 64 | Current time {seconds, ticks} |

## Verification
Two pairs of events can fall in the same cycle.

The first pair is a load and a ticks rollover. The bench holds a rate of 10 and lets ticks reach 9. In that cycle it issues an immediate load, then checks that the staged value appears rather than the wrapped one.

The second pair is a PPS edge and the write that arms a load. The bench changes the selected input and counts two clocks, so that the arming write is taken in exactly the cycle in which the sampler reports the edge. It checks that the time does not change in that cycle, and that the next active edge does load.

// File: rtl/tk_pkg.sv
package tk_pkg;
  localparam int unsigned IDX_W_D     = 5;
  localparam int unsigned IDX_SECS_D  = 28;
  localparam int unsigned IDX_TICKS_D = 29;
  localparam int unsigned IDX_FLAGS_D = 30;
  localparam int unsigned IDX_CTL_D   = 31;

  typedef struct packed {
    logic src_b2b;  // bit 1: 0 external, 1 board-to-board
    logic rise;     // bit 0: 0 falling, 1 rising
  } tk_flags_t;
endpackage

// File: rtl/tk_pps_edge.sv
module tk_pps_edge #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pps_a,
  input  logic            pps_b,
  input  tk_pkg::tk_flags_t flags,
  output logic            pps_edge
);
  logic                   pps_sel;
  logic [SYNC_STAGES-1:0] samp;
  logic                   prev;

  assign pps_sel = flags.src_b2b ? pps_b : pps_a;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) samp <= '0;
        else     samp <= pps_sel;
      end
    end else begin : g_chain
      always_ff @(posedge clk) begin
        if (rst) samp <= '0;
        else     samp <= {samp[SYNC_STAGES-2:0], pps_sel};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev <= 1'b0;
    else     prev <= samp[SYNC_STAGES-1];
  end

  assign pps_edge = flags.rise ? (samp[SYNC_STAGES-1] & ~prev)
                               : (~samp[SYNC_STAGES-1] & prev);
endmodule

// File: rtl/tk_cfg_regs.sv
module tk_cfg_regs #(
  parameter int unsigned IDX_W     = tk_pkg::IDX_W_D,
  parameter int unsigned DATA_W    = 32,
  parameter int unsigned SEC_W     = 32,
  parameter int unsigned TICK_W    = 32,
  parameter int unsigned IDX_SECS  = tk_pkg::IDX_SECS_D,
  parameter int unsigned IDX_TICKS = tk_pkg::IDX_TICKS_D,
  parameter int unsigned IDX_FLAGS = tk_pkg::IDX_FLAGS_D,
  parameter int unsigned IDX_CTL   = tk_pkg::IDX_CTL_D
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] data,
  input  logic              pps_edge,
  output logic [SEC_W-1:0]  pend_sec,
  output logic [TICK_W-1:0] pend_ticks,
  output tk_pkg::tk_flags_t flags,
  output logic              armed,
  output logic              load
);
  logic hit_sec, hit_tick, hit_flag, hit_ctl, imm, arm;

  assign hit_sec  = wr && (idx == IDX_W'(IDX_SECS));
  assign hit_tick = wr && (idx == IDX_W'(IDX_TICKS));
  assign hit_flag = wr && (idx == IDX_W'(IDX_FLAGS));
  assign hit_ctl  = wr && (idx == IDX_W'(IDX_CTL));
  assign imm      = hit_ctl && data[0];
  assign arm      = hit_ctl && !data[0];

  // armed state is the one before this cycle, so an edge together
  // with the arming write does not load
  assign load = imm || (armed && pps_edge);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_sec   <= '0;
      pend_ticks <= '0;
      flags      <= '0;
    end else begin
      if (hit_sec)  pend_sec   <= SEC_W'(data);
      if (hit_tick) pend_ticks <= TICK_W'(data);
      if (hit_flag) flags      <= tk_pkg::tk_flags_t'(data[1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           armed <= 1'b0;
    else if (imm)      armed <= 1'b0;
    else if (arm)      armed <= 1'b1;
    else if (pps_edge) armed <= 1'b0;
  end
endmodule

// File: rtl/tk_counter.sv
module tk_counter #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TICK_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SEC_W-1:0]  ld_sec,
  input  logic [TICK_W-1:0] ld_ticks,
  input  logic [TICK_W-1:0] rate,
  output logic [SEC_W-1:0]  sec,
  output logic [TICK_W-1:0] ticks
);
  logic [TICK_W:0] nxt;
  logic            wrap;

  assign nxt  = {1'b0, ticks} + 1'b1;
  assign wrap = nxt >= {1'b0, rate};

  always_ff @(posedge clk) begin
    if (rst) begin
      sec   <= '0;
      ticks <= '0;
    end else if (load) begin
      sec   <= ld_sec;
      ticks <= ld_ticks;
    end else if (wrap) begin
      sec   <= sec + 1'b1;
      ticks <= '0;
    end else begin
      ticks <= nxt[TICK_W-1:0];
    end
  end
endmodule

// File: rtl/pps_timekeeper.sv
module pps_timekeeper #(
  parameter int unsigned IDX_W       = tk_pkg::IDX_W_D,
  parameter int unsigned DATA_W      = 32,
  parameter int unsigned SEC_W       = 32,
  parameter int unsigned TICK_W      = 32,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned TIME_W     = SEC_W + TICK_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic [IDX_W-1:0]  cfg_idx,
  input  logic [DATA_W-1:0] cfg_data,
  input  logic [TICK_W-1:0] tick_rate,
  input  logic              pps_ext,
  input  logic              pps_b2b,
  output logic [TIME_W-1:0] time_now
);
  tk_pkg::tk_flags_t flags;
  logic              pps_edge, armed, load_now;
  logic [SEC_W-1:0]  pend_sec, cur_sec;
  logic [TICK_W-1:0] pend_ticks, cur_ticks;

  tk_cfg_regs #(
    .IDX_W(IDX_W), .DATA_W(DATA_W), .SEC_W(SEC_W), .TICK_W(TICK_W)
  ) u_cfg (
    .clk(clk), .rst(rst), .wr(cfg_wr), .idx(cfg_idx), .data(cfg_data),
    .pps_edge(pps_edge), .pend_sec(pend_sec), .pend_ticks(pend_ticks),
    .flags(flags), .armed(armed), .load(load_now)
  );

  tk_pps_edge #(.SYNC_STAGES(SYNC_STAGES)) u_pps (
    .clk(clk), .rst(rst), .pps_a(pps_ext), .pps_b(pps_b2b),
    .flags(flags), .pps_edge(pps_edge)
  );

  tk_counter #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_cnt (
    .clk(clk), .rst(rst), .load(load_now), .ld_sec(pend_sec),
    .ld_ticks(pend_ticks), .rate(tick_rate), .sec(cur_sec), .ticks(cur_ticks)
  );

  assign time_now = {cur_sec, cur_ticks};
endmodule

// File: rtl/tk_checker.sv
module tk_checker #(
  parameter int unsigned SEC_W  = 32,
  parameter int unsigned TICK_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              load_now,
  input logic              armed,
  input logic              pps_edge,
  input logic [SEC_W-1:0]  pend_sec,
  input logic [TICK_W-1:0] pend_ticks,
  input logic [SEC_W-1:0]  cur_sec,
  input logic [TICK_W-1:0] cur_ticks,
  input logic [TICK_W-1:0] tick_rate
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (cur_sec == '0 && cur_ticks == '0 && !armed));

  // R2
  tick_step_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_now && ({1'b0, cur_ticks} + 1'b1) < {1'b0, tick_rate})
      |=> (cur_ticks == $past(cur_ticks) + 1'b1 && cur_sec == $past(cur_sec)));

  // R2
  rollover_chk: assert property (@(posedge clk) disable iff (rst)
    (!load_now && ({1'b0, cur_ticks} + 1'b1) >= {1'b0, tick_rate})
      |=> (cur_ticks == '0 && cur_sec == $past(cur_sec) + 1'b1));

  // R9
  load_wins_chk: assert property (@(posedge clk) disable iff (rst)
    load_now |=> (cur_sec == $past(pend_sec) && cur_ticks == $past(pend_ticks)));

  // R5
  armed_fires_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && pps_edge) |-> load_now);

  // R5
  armed_holds_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !pps_edge && !cfg_wr) |=> armed);
endmodule

bind pps_timekeeper tk_checker #(.SEC_W(SEC_W), .TICK_W(TICK_W)) u_chk (
  .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .load_now(load_now), .armed(armed),
  .pps_edge(pps_edge), .pend_sec(pend_sec), .pend_ticks(pend_ticks),
  .cur_sec(cur_sec), .cur_ticks(cur_ticks), .tick_rate(tick_rate)
);

// File: tb/pps_timekeeper_tb.sv
module pps_timekeeper_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_wr = 1'b0;
  logic [4:0]  cfg_idx = '0;
  logic [31:0] cfg_data = '0;
  logic [31:0] tick_rate = 32'd1000;
  logic        pps_ext = 1'b0;
  logic        pps_b2b = 1'b0;
  logic [63:0] time_now;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  pps_timekeeper u_dut (
    .clk(clk), .rst(rst), .cfg_wr(cfg_wr), .cfg_idx(cfg_idx),
    .cfg_data(cfg_data), .tick_rate(tick_rate), .pps_ext(pps_ext),
    .pps_b2b(pps_b2b), .time_now(time_now)
  );

  task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic check_true(input string req, input logic cond, input logic [63:0] got);
    n_tests++;
    if (cond !== 1'b1) begin
      n_fail++;
      $display("FAIL %s: got %h expected condition to hold", req, got);
    end
  endtask

  // called at a negedge; returns at the next negedge
  task automatic wr_reg(input int idx, input logic [31:0] d);
    cfg_wr = 1'b1; cfg_idx = 5'(idx); cfg_data = d;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    check("R1 reset time", time_now, 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 count starts", time_now, 64'd1);
  endtask

  task automatic t_stage_and_load;
    logic [63:0] t0;
    t0 = time_now;
    wr_reg(28, 32'd5);
    wr_reg(29, 32'd10);
    check("R3 staging leaves time", time_now, t0 + 64'd2);
    wr_reg(12, 32'd77);
    check("R3 other index ignored", time_now, t0 + 64'd3);
    wr_reg(31, 32'd1);
    check("R4 immediate load", time_now, {32'd5, 32'd10});
    @(negedge clk);
    check("R4 counts after load", time_now, {32'd5, 32'd11});
  endtask

  task automatic t_rollover;
    tick_rate = 32'd10;
    wr_reg(28, 32'd7);
    wr_reg(29, 32'd8);
    wr_reg(31, 32'd1);
    check("R2 load before wrap", time_now, {32'd7, 32'd8});
    @(negedge clk);
    check("R2 tick 9", time_now, {32'd7, 32'd9});
    @(negedge clk);
    check("R2 rollover", time_now, {32'd8, 32'd0});
  endtask

  task automatic t_load_vs_wrap;
    wr_reg(28, 32'd50);
    wr_reg(29, 32'd5);
    wr_reg(31, 32'd1);
    wait_n(4);
    check("R9 at tick 9", time_now, {32'd50, 32'd9});
    wr_reg(31, 32'd1);
    check("R9 load beats rollover", time_now, {32'd50, 32'd5});
  endtask

  task automatic t_rate_one;
    tick_rate = 32'd1;
    wr_reg(28, 32'd3);
    wr_reg(29, 32'd0);
    wr_reg(31, 32'd1);
    check("R2 rate1 load", time_now, {32'd3, 32'd0});
    @(negedge clk);
    check("R2 rate1 step", time_now, {32'd4, 32'd0});
    tick_rate = 32'd1000;
  endtask

  task automatic t_pps_falling;
    wr_reg(30, 32'd0);
    wr_reg(28, 32'd200);
    wr_reg(29, 32'd0);
    wr_reg(31, 32'd0);
    pps_ext = 1'b1;
    wait_n(4);
    check_true("R6 rising ignored", time_now[63:32] != 32'd200, time_now);
    pps_ext = 1'b0;
    wait_n(2);
    check_true("R8 not before third edge", time_now[63:32] != 32'd200, time_now);
    @(negedge clk);
    check("R8 R5 load on falling", time_now, {32'd200, 32'd0});
    @(negedge clk);
    check("R5 counting after", time_now, {32'd200, 32'd1});
    wr_reg(28, 32'd250);
    pps_ext = 1'b1; wait_n(4);
    pps_ext = 1'b0; wait_n(4);
    check("R5 single shot", 64'(time_now[63:32]), 64'd200);
  endtask

  task automatic t_pps_source;
    wr_reg(30, 32'd3);
    wr_reg(28, 32'd300);
    wr_reg(29, 32'd0);
    wr_reg(31, 32'd0);
    pps_ext = 1'b1; wait_n(4);
    pps_ext = 1'b0; wait_n(4);
    check("R7 other input ignored", 64'(time_now[63:32]), 64'd200);
    pps_b2b = 1'b1;
    wait_n(2);
    check("R7 not yet", 64'(time_now[63:32]), 64'd200);
    @(negedge clk);
    check("R7 R6 rising b2b load", time_now, {32'd300, 32'd0});
  endtask

  task automatic t_imm_disarms;
    wr_reg(28, 32'd400);
    wr_reg(29, 32'd0);
    wr_reg(31, 32'd0);
    wr_reg(31, 32'd1);
    check("R10 immediate while armed", time_now, {32'd400, 32'd0});
    wr_reg(28, 32'd500);
    pps_b2b = 1'b0; wait_n(4);
    pps_b2b = 1'b1; wait_n(4);
    check("R10 disarmed", 64'(time_now[63:32]), 64'd400);
  endtask

  task automatic t_arm_same_cycle;
    pps_b2b = 1'b0; wait_n(4);
    wr_reg(28, 32'd600);
    pps_b2b = 1'b1;
    wait_n(2);
    wr_reg(31, 32'd0);
    check("R11 no load with arming edge", 64'(time_now[63:32]), 64'd400);
    pps_b2b = 1'b0; wait_n(4);
    pps_b2b = 1'b1; wait_n(3);
    check("R11 loads on next edge", time_now, {32'd600, 32'd0});
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    wait_n(3);
    t_reset();
    t_stage_and_load();
    t_rollover();
    t_load_vs_wrap();
    t_rate_one();
    t_pps_falling();
    t_pps_source();
    t_imm_disarms();
    t_arm_same_cycle();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule